// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in, first-out buffer with nine-bit words. It has separate write and read clock domains, and the two clocks may also be driven from a single shared source. Each side accepts an access only when a pair of enable inputs agree: one enable is active low and the other is active high. The read data goes out through an active-low output enable. When that enable is high, the data pins float.

The write and read pointers are each one bit wider than the address. They are kept in Gray code and cross into the opposite domain through two-flop synchronizers. Full is decided in the write domain and Empty in the read domain. Two further flags warn of the edges: one when few words remain to read, and one when little free space remains. Each of these flags has its own threshold register, and both thresholds reset to 7.

The level of the active-high write enable at the first write-clock edge after reset release selects the mode. If that enable is low, the port enters a load mode. In load mode, the same pin acts as a load strobe, and it writes the two threshold registers from the data input one after the other.

Top module: `flagfifo_top`

## Requirements
- R1: After the asynchronous active-low reset, `emptyFlag`=1, `nearEmpty`=1, `fullFlag`=0 and `nearFull`=0. With `outEnN`=0, `dOut` reads 0.
- R2: After the first write-clock edge that follows reset release, `dIn` is stored at a rising `wrClk` edge when `wrEnN`=0 and `wrEnLd`=1 and the FIFO is not full.
- R3: At a rising `rdClk` edge with `rdEnN`=0, `rdEn`=1 and the FIFO not empty, the oldest word is removed. It appears on `dOut` after that edge, and words leave in the order they were written.
- R4: `outEnN`=1 puts `dOut` in high impedance. It does not change the stored data, and the held word returns on `dOut` once `outEnN` goes back to 0.
- R5: A write attempted while `fullFlag`=1 is ignored. The stored words are neither overwritten nor added to.
- R6: A read attempted while `emptyFlag`=1 is ignored. `dOut` holds its value and the read position does not advance.
- R7: When the FIFO has been idle for four cycles, `emptyFlag`=1 exactly when 0 words are stored and `fullFlag`=1 exactly when 2^ADDR_W words are stored. The default depth is 64.
- R8: `nearEmpty`=1 when the stored count is at or below the empty-side threshold. `nearFull`=1 when the free space is at or below the full-side threshold. Both thresholds reset to DEF_OFFSET=7.
- R9: If `wrEnLd`=0 at the first `wrClk` edge after reset release, load mode is selected. No access happens on that edge. In load mode, each edge with `wrEnN`=0 and `wrEnLd`=0 loads `dIn[ADDR_W-1:0]`, first into the empty-side threshold and then into the full-side threshold, and stores no data word.
- R10: With unrelated write and read clocks, every accepted word is read back in order. Each pointer's Gray code changes by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEnN | input | 1 | Write enable, active low |
| wrEnLd | input | 1 | Write enable, active high; load strobe in load mode |
| rdEnN | input | 1 | Read enable, active low |
| rdEn | input | 1 | Read enable, active high |
| outEnN | input | 1 | Output enable for dOut, active low |
| dIn | input | 9 | Write data and threshold load value |
| dOut | output | 9 | Read data, high impedance when disabled |
| emptyFlag | output | 1 | No word visible to the read side |
| fullFlag | output | 1 | No free slot visible to the write side |
| nearEmpty | output | 1 | Stored count at or below empty-side threshold |
| nearFull | output | 1 | Free space at or below full-side threshold |

## Verification
Several properties are checked on every edge of the clock concerned:
- Each pointer's Gray code changes by at most one bit.
- The pointer distance seen in each domain never exceeds the depth.
- An ignored access leaves its pointer unchanged.
- Full implies near-full, and Empty implies near-empty.
- The two threshold loads never fire together.

Only the bench's scenarios can show the rest. These cover data ordering across both clocking schemes, the absence of overwrite after a refused write, threshold behaviour at exact boundary counts after a load, and the floating output.

// File: rtl/flagfifo_pkg.sv
package flagfifo_pkg;
  // Strobes the control side hands to the datapath each cycle.
  typedef struct packed {
    logic wrStore;  // commit dIn into the array (write domain)
    logic rdFetch;  // move the addressed word to the output register (read domain)
    logic aeLoad;   // load empty-side threshold (write domain)
    logic afLoad;   // load full-side threshold (write domain)
  } fifoStrobes_t;
endpackage

// File: rtl/flagfifo_ctrl.sv
module flagfifo_ctrl
  import flagfifo_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEnN,
  input  logic              wrEnLd,
  input  logic              rdEnN,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] aeOff,
  input  logic [ADDR_W-1:0] afOff,
  output fifoStrobes_t      strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              emptyFlag,
  output logic              fullFlag,
  output logic              nearEmpty,
  output logic              nearFull
);
  localparam int PW = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] toBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0] wrBin, wrGray, rdGraySync1, rdGraySync2, rdBinSync, wrCount;
  logic started, loadMode, loadSel;
  logic wrReq, ldReq;

  assign wrReq = started && !wrEnN && wrEnLd;
  assign ldReq = started && loadMode && !wrEnN && !wrEnLd;

  assign rdBinSync = toBin(rdGraySync2);
  assign wrCount   = wrBin - rdBinSync;
  assign fullFlag  = (wrGray == {~rdGraySync2[PW-1:PW-2], rdGraySync2[PW-3:0]});
  assign nearFull  = (PW'(DEPTH) - wrCount) <= {1'b0, afOff};

  assign strobes.wrStore = wrReq && !fullFlag;
  assign strobes.aeLoad  = ldReq && !loadSel;
  assign strobes.afLoad  = ldReq && loadSel;
  assign wrAddr = wrBin[ADDR_W-1:0];

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin       <= '0;
      wrGray      <= '0;
      rdGraySync1 <= '0;
      rdGraySync2 <= '0;
      started     <= 1'b0;
      loadMode    <= 1'b0;
      loadSel     <= 1'b0;
    end else begin
      started     <= 1'b1;
      rdGraySync1 <= rdGray;
      rdGraySync2 <= rdGraySync1;
      if (!started) loadMode <= !wrEnLd;
      if (ldReq) loadSel <= !loadSel;
      if (strobes.wrStore) begin
        wrBin  <= wrBin + PW'(1);
        wrGray <= toGray(wrBin + PW'(1));
      end
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rdBin, rdGray, wrGraySync1, wrGraySync2, rdCount;
  logic rdReq;

  assign rdReq     = !rdEnN && rdEn;
  assign emptyFlag = (rdGray == wrGraySync2);
  assign rdCount   = toBin(wrGraySync2) - rdBin;
  assign nearEmpty = rdCount <= {1'b0, aeOff};
  assign strobes.rdFetch = rdReq && !emptyFlag;
  assign rdAddr = rdBin[ADDR_W-1:0];

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin       <= '0;
      rdGray      <= '0;
      wrGraySync1 <= '0;
      wrGraySync2 <= '0;
    end else begin
      wrGraySync1 <= wrGray;
      wrGraySync2 <= wrGraySync1;
      if (strobes.rdFetch) begin
        rdBin  <= rdBin + PW'(1);
        rdGray <= toGray(rdBin + PW'(1));
      end
    end
  end

  // ---------------- assertions ----------------
  a_r10_wr_gray_step: assert property (@(posedge wrClk) disable iff (!rstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);
  a_r10_rd_gray_step: assert property (@(posedge rdClk) disable iff (!rstN)
    $countones(rdGray ^ $past(rdGray)) <= 1);
  a_r5_no_overflow: assert property (@(posedge wrClk) disable iff (!rstN)
    wrCount <= PW'(DEPTH));
  a_r6_no_underflow: assert property (@(posedge rdClk) disable iff (!rstN)
    rdCount <= PW'(DEPTH));
  a_r5_full_holds_ptr: assert property (@(posedge wrClk) disable iff (!rstN)
    (fullFlag && wrReq) |=> $stable(wrBin));
  a_r6_empty_holds_ptr: assert property (@(posedge rdClk) disable iff (!rstN)
    (emptyFlag && rdReq) |=> $stable(rdBin));
  a_r8_full_implies_near: assert property (@(posedge wrClk) disable iff (!rstN)
    fullFlag |-> nearFull);
  a_r8_empty_implies_near: assert property (@(posedge rdClk) disable iff (!rstN)
    emptyFlag |-> nearEmpty);
endmodule

// File: rtl/flagfifo_dpath.sv
module flagfifo_dpath
  import flagfifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 6,
  parameter int DEF_OFFSET = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] dIn,
  output logic [ADDR_W-1:0] aeOff,
  output logic [ADDR_W-1:0] afOff,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobes.wrStore) mem[wrAddr] <= dIn;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      aeOff <= ADDR_W'(DEF_OFFSET);
      afOff <= ADDR_W'(DEF_OFFSET);
    end else begin
      if (strobes.aeLoad) aeOff <= ADDR_W'(dIn);
      if (strobes.afLoad) afOff <= ADDR_W'(dIn);
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strobes.rdFetch) rdData <= mem[rdAddr];
  end

  a_r9_one_load: assert property (@(posedge wrClk) disable iff (!rstN)
    $onehot0({strobes.aeLoad, strobes.afLoad, strobes.wrStore}));
  a_r6_hold_data: assert property (@(posedge rdClk) disable iff (!rstN)
    !strobes.rdFetch |=> $stable(rdData));
endmodule

// File: rtl/flagfifo_top.sv
module flagfifo_top
  import flagfifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 6,
  parameter int DEF_OFFSET = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEnN,
  input  logic              wrEnLd,
  input  logic              rdEnN,
  input  logic              rdEn,
  input  logic              outEnN,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              emptyFlag,
  output logic              fullFlag,
  output logic              nearEmpty,
  output logic              nearFull
);
  fifoStrobes_t      strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr, aeOff, afOff;
  logic [DATA_W-1:0] rdData;

  flagfifo_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnN(wrEnN), .wrEnLd(wrEnLd), .rdEnN(rdEnN), .rdEn(rdEn),
    .aeOff(aeOff), .afOff(afOff), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .emptyFlag(emptyFlag), .fullFlag(fullFlag),
    .nearEmpty(nearEmpty), .nearFull(nearFull)
  );

  flagfifo_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEF_OFFSET(DEF_OFFSET)) dpath_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .dIn(dIn),
    .aeOff(aeOff), .afOff(afOff), .rdData(rdData)
  );

  assign dOut = outEnN ? {DATA_W{1'bz}} : rdData;
endmodule

// File: tb/flagfifo_tb.sv
`timescale 1ns/1ps
module flagfifo_top_tb_top;
  localparam int DEPTH = 64;

  logic clk = 1'b0, altClk = 1'b0, tieClk = 1'b1;
  logic rdClk;
  always #2.5 clk = ~clk;
  always #3.5 altClk = ~altClk;
  assign rdClk = tieClk ? clk : altClk;

  logic rstN, wrEnN, wrEnLd, rdEnN, rdEn, outEnN;
  logic [8:0] dIn, dOut;
  logic emptyFlag, fullFlag, nearEmpty, nearFull;

  flagfifo_top dut_i (
    .wrClk(clk), .rdClk(rdClk), .rstN(rstN), .wrEnN(wrEnN), .wrEnLd(wrEnLd),
    .rdEnN(rdEnN), .rdEn(rdEn), .outEnN(outEnN), .dIn(dIn), .dOut(dOut),
    .emptyFlag(emptyFlag), .fullFlag(fullFlag), .nearEmpty(nearEmpty), .nearFull(nearFull)
  );

  int total = 0, bad = 0;
  int q[$];
  int aeModel = 7, afModel = 7;
  int lastRd = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #750000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  task automatic doReset(input bit ldLow);
    rstN = 1'b0; wrEnN = 1'b1; wrEnLd = ldLow ? 1'b0 : 1'b1;
    rdEnN = 1'b1; rdEn = 1'b0; outEnN = 1'b0; dIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);  // first edge after release samples the mode only
    q.delete(); aeModel = 7; afModel = 7; lastRd = 0;
  endtask

  // One shared-clock cycle; called and returns at a falling edge.
  task automatic cycle(input bit doWr, input int wd, input bit doRd);
    bit wa, ra;
    int exp;
    wa = doWr && !fullFlag;
    ra = doRd && !emptyFlag;
    wrEnN = !doWr; wrEnLd = 1'b1; dIn = 9'(wd);
    rdEnN = !doRd; rdEn = doRd;
    @(posedge clk);
    @(negedge clk);
    wrEnN = 1'b1; rdEnN = 1'b1; rdEn = 1'b0;
    if (ra) begin
      exp = q.pop_front();
      lastRd = exp;
      check(dOut == 9'(exp), "R3 read order", dOut, exp);
    end
    if (wa) q.push_back(wd & 9'h1ff);
  endtask

  task automatic settle();
    repeat (4) cycle(0, 0, 0);
    check(emptyFlag == (q.size() == 0), "R7 empty", emptyFlag, q.size() == 0);
    check(fullFlag == (q.size() == DEPTH), "R7 full", fullFlag, q.size() == DEPTH);
    check(nearEmpty == (q.size() <= aeModel), "R8 near empty", nearEmpty, q.size() <= aeModel);
    check(nearFull == ((DEPTH - q.size()) <= afModel), "R8 near full", nearFull,
          (DEPTH - q.size()) <= afModel);
  endtask

  initial begin
    void'($urandom(32'd2024));
    // ---- R1 reset state ----
    doReset(1'b0);
    check(emptyFlag == 1, "R1 empty", emptyFlag, 1);
    check(nearEmpty == 1, "R1 near empty", nearEmpty, 1);
    check(fullFlag == 0, "R1 full", fullFlag, 0);
    check(nearFull == 0, "R1 near full", nearFull, 0);
    check(dOut == 0, "R1 dout", dOut, 0);

    // ---- R6 read on empty ignored ----
    cycle(0, 0, 1);
    check(dOut == 0, "R6 dout held", dOut, 0);
    check(emptyFlag == 1, "R6 still empty", emptyFlag, 1);
    cycle(1, 9'h0c3, 0);
    settle();
    cycle(0, 0, 1);  // R6: read pointer did not move, first word comes out
    settle();

    // ---- R2/R3 random mix ----
    for (int i = 0; i < 600; i++) begin
      cycle(($urandom % 100) < 55, $urandom, ($urandom % 100) < 45);
      if (i % 75 == 74) settle();
    end
    while (q.size() > 0) cycle(0, 0, 1);
    settle();

    // ---- R8 boundaries with default thresholds ----
    repeat (7) cycle(1, $urandom, 0);
    settle();  // 7 stored: near empty
    cycle(1, $urandom, 0);
    settle();  // 8 stored: not near empty
    while (q.size() < DEPTH - 8) cycle(1, $urandom, 0);
    settle();  // free 8: not near full
    cycle(1, $urandom, 0);
    settle();  // free 7: near full

    // ---- R5 write on full ignored ----
    while (q.size() < DEPTH) cycle(1, $urandom, 0);
    settle();
    repeat (5) cycle(1, 9'h1aa, 0);
    settle();
    check(q.size() == DEPTH, "R5 count", q.size(), DEPTH);
    while (q.size() > 0) cycle(0, 0, 1);  // R5: original words, in order
    settle();

    // ---- R4 output enable ----
    cycle(1, 9'h15a, 0);
    repeat (3) cycle(0, 0, 0);
    cycle(0, 0, 1);
    outEnN = 1'b1;
    #1;
    check(dOut === 9'bz, "R4 float", dOut, 9'h1ff);
    repeat (2) @(negedge clk);
    outEnN = 1'b0;
    #1;
    check(dOut == 9'h15a, "R4 restore", dOut, 9'h15a);
    @(negedge clk);

    // ---- R9 load mode ----
    doReset(1'b1);
    wrEnLd = 1'b0; wrEnN = 1'b0; dIn = 9'd3;
    @(negedge clk);
    dIn = 9'd5;
    @(negedge clk);
    wrEnN = 1'b1; wrEnLd = 1'b1;
    aeModel = 3; afModel = 5;
    settle();  // R9: loads stored no data word
    repeat (3) cycle(1, $urandom, 0);
    settle();
    cycle(1, $urandom, 0);
    settle();
    while (q.size() < DEPTH - 6) cycle(1, $urandom, 0);
    settle();
    cycle(1, $urandom, 0);
    settle();
    while (q.size() > 0) cycle(0, 0, 1);

    // ---- R10 unrelated clocks ----
    tieClk = 1'b0;
    doReset(1'b0);
    fork
      begin : writer
        int sent = 0;
        while (sent < 300) begin
          bit w, wa;
          int wd;
          @(negedge clk);
          w = ($urandom % 100) < 70;
          wd = $urandom & 9'h1ff;
          wa = w && !fullFlag;
          wrEnN = !w; wrEnLd = 1'b1; dIn = 9'(wd);
          @(posedge clk);
          if (wa) begin q.push_back(wd); sent++; end
        end
        @(negedge clk);
        wrEnN = 1'b1;
      end
      begin : reader
        int got = 0;
        bit pend = 0;
        int exp = 0;
        while (got < 300) begin
          bit r;
          @(negedge rdClk);
          if (pend) begin
            check(dOut == 9'(exp), "R10 async order", dOut, exp);
            got++;
            pend = 0;
          end
          r = ($urandom % 100) < 60;
          rdEnN = !r; rdEn = r;
          if (r && !emptyFlag && got < 300) begin
            exp = q.pop_front();
            pend = 1;
          end
        end
        rdEnN = 1'b1; rdEn = 1'b0;
      end
    join
    repeat (6) @(negedge clk);
    check(emptyFlag == 1, "R10 drained empty", emptyFlag, 1);
    summary();
  end
endmodule